// File: doc/BRIEF.md
# Drain-Time Event Validity Filter

This block screens event records as they stream back on-chip from an off-chip list on their way to a small sorting queue. Each record carries an event time, the time at which the event was predicted, one or two bead identifiers, and a flag that says whether the second bead identifier is in use. Events are not deleted while they are stored off-chip. Instead, the filter decides whether each record is still valid at the moment it is drained.

The filter holds an on-chip table with the time of the most recent event for each bead. For every incoming record it reads the entries for the record's beads. It forwards the record only if none of those beads has taken part in an event later than the record's prediction time. Otherwise the record is discarded.

The event processor writes new last-event times through a separate update port. If an update lands in the same cycle as a lookup of the same bead, the lookup sees the new time. The filter accepts one record per clock, has a fixed two-cycle latency, and keeps running counts of the records it forwarded and the records it discarded.

Top module: `evf_drain_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0. Both `pass_count` and `drop_count` read 0.
- R2: A record presented with `in_valid`=1 in cycle c that is judged valid appears in cycle c+2 with `out_valid`=1, and every output field equals the input field.
- R3: A bead that has never been written since reset has a last-event time of 0.
- R4: A record is discarded (no `out_valid` in cycle c+2) when the last-event time of bead A is strictly greater than its prediction time.
- R5: A record whose bead last-event time equals its prediction time is kept.
- R6: When `in_b_used`=1, a record is discarded if the last-event time of bead B is strictly greater than its prediction time.
- R7: When `in_b_used`=0, the value of `in_bead_b` and the time stored for that bead have no effect on the decision.
- R8: An update (`upd_en`=1) of a bead in the same cycle as a lookup of that bead is used by that lookup in place of the stored time. From the next cycle on, the update also holds for later lookups.
- R9: Records presented in consecutive cycles are each judged, and each appears two cycles later, with no gaps or stalls.
- R10: `pass_count` rises by exactly 1 in the cycle a record is forwarded, and `drop_count` rises by exactly 1 in the cycle a record would have appeared but was discarded. Neither counter changes otherwise; both wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Drained record present this cycle |
| in_evt_time | input | 32 | Scheduled event time |
| in_pred_time | input | 32 | Time the event was predicted |
| in_bead_a | input | 16 | First bead identifier |
| in_bead_b | input | 16 | Second bead identifier |
| in_b_used | input | 1 | 1 when the second bead identifier is meaningful |
| upd_en | input | 1 | Write a bead's last-event time |
| upd_bead | input | 16 | Bead to update |
| upd_time | input | 32 | New last-event time |
| out_valid | output | 1 | Surviving record present |
| out_evt_time | output | 32 | Event time of surviving record |
| out_pred_time | output | 32 | Prediction time of surviving record |
| out_bead_a | output | 16 | First bead of surviving record |
| out_bead_b | output | 16 | Second bead of surviving record |
| out_b_used | output | 1 | Second-bead flag of surviving record |
| pass_count | output | CNT_W (16) | Records forwarded since reset |
| drop_count | output | CNT_W (16) | Records discarded since reset |

## Verification
A bead-time update and a lookup of the same bead can fall in the same cycle. The bench provokes this by raising `upd_en` in the cycle a record naming that bead is presented.

Two cases are judged. In the first, the stored time is older than the prediction time and the new time is newer, so the record must be discarded. In the second, the stored time is newer and the new time is older, so the record must pass. A design that reads the stored value instead of the update fails both cases.

Back-to-back streams then mix kept and discarded records to show that the decisions and counts line up cycle by cycle.

// File: rtl/evf_pkg.sv
// Shared widths and the drained event record type for the validity filter.
package evf_pkg;
    localparam int TS_W = 32;   // timestamp width
    localparam int ID_W = 16;   // bead identifier width

    // One drained event record as it travels through the filter.
    typedef struct packed {
        logic [TS_W-1:0] evt_time;
        logic [TS_W-1:0] pred_time;
        logic [ID_W-1:0] bead_a;
        logic [ID_W-1:0] bead_b;
        logic            b_used;
    } evf_rec_t;
endpackage

// File: rtl/evf_bead_store.sv
// Bead last-event-time table: one write port, NRD registered read ports.
// Assumes bead identifiers are below DEPTH; only the low address bits are used.
// Entries never written since reset read as time zero. A write to the bead
// being read in the same cycle is forwarded into that read result.
module evf_bead_store
    import evf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ID_W-1:0]           wr_id,
    input  logic [TS_W-1:0]           wr_time,
    input  logic [NRD-1:0][ID_W-1:0]  rd_id,
    output logic [NRD-1:0][TS_W-1:0]  rd_time
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [TS_W-1:0]  times [DEPTH];
    logic [DEPTH-1:0] seen;
    logic [AW-1:0]    wr_addr;

    assign wr_addr = wr_id[AW-1:0];

    // Storage array update; contents need no reset because of the seen bits.
    always_ff @(posedge clk) begin
        if (wr_en) times[wr_addr] <= wr_time;
    end

    // Per-entry written-since-reset flags.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen <= '0;
        else if (wr_en) seen[wr_addr] <= 1'b1;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [AW-1:0] rd_addr;
        logic          hit_wr;
        assign rd_addr = rd_id[p][AW-1:0];
        assign hit_wr  = wr_en && (wr_addr == rd_addr);

        // Registered read with same-cycle write forwarding.
        always_ff @(posedge clk) begin
            if (!rst_n)             rd_time[p] <= '0;
            else if (hit_wr)        rd_time[p] <= wr_time;
            else if (seen[rd_addr]) rd_time[p] <= times[rd_addr];
            else                    rd_time[p] <= '0;
        end
    end
endmodule

// File: rtl/evf_stale_check.sv
// Combinational validity decision for one record.
// A bead is stale when its last-event time is strictly later than the record's
// prediction time; the second bead counts only when the record flags it used.
module evf_stale_check
    import evf_pkg::*;
(
    input  evf_rec_t        rec,
    input  logic [TS_W-1:0] last_a,
    input  logic [TS_W-1:0] last_b,
    output logic            keep
);
    logic stale_a;
    logic stale_b;

    // Compare both lookups against the prediction time.
    always_comb begin
        stale_a = last_a > rec.pred_time;
        stale_b = rec.b_used && (last_b > rec.pred_time);
        keep    = !(stale_a || stale_b);
    end
endmodule

// File: rtl/evf_tally.sv
// Wrapping event counter with synchronous active-low clear.
module evf_tally #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);
    // Count one per asserted bump.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + 1'b1;
    end
endmodule

// File: rtl/evf_drain_filter.sv
// Drain-time event validity filter.
// Stage 1 registers the incoming record while the bead table reads both beads.
// Stage 2 judges the record and registers the survivor plus the counters.
// Assumes one record per cycle at most and bead identifiers below BEAD_DEPTH.
module evf_drain_filter
    import evf_pkg::*;
#(
    parameter int BEAD_DEPTH = 1024,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_evt_time,
    input  logic [31:0]      in_pred_time,
    input  logic [15:0]      in_bead_a,
    input  logic [15:0]      in_bead_b,
    input  logic             in_b_used,
    input  logic             upd_en,
    input  logic [15:0]      upd_bead,
    input  logic [31:0]      upd_time,
    output logic             out_valid,
    output logic [31:0]      out_evt_time,
    output logic [31:0]      out_pred_time,
    output logic [15:0]      out_bead_a,
    output logic [15:0]      out_bead_b,
    output logic             out_b_used,
    output logic [CNT_W-1:0] pass_count,
    output logic [CNT_W-1:0] drop_count
);
    localparam int NRD = 2;

    evf_rec_t                 in_rec;
    evf_rec_t                 s1_rec;
    logic                     s1_valid;
    evf_rec_t                 s2_rec;
    logic                     s2_valid;
    logic [NRD-1:0][ID_W-1:0] look_id;
    logic [NRD-1:0][TS_W-1:0] look_time;
    logic                     keep;
    logic                     pass_now;
    logic                     drop_now;

    // Pack the input ports into a record and choose the lookup keys.
    always_comb begin
        in_rec.evt_time  = in_evt_time;
        in_rec.pred_time = in_pred_time;
        in_rec.bead_a    = in_bead_a;
        in_rec.bead_b    = in_bead_b;
        in_rec.b_used    = in_b_used;
        look_id[0]       = in_bead_a;
        look_id[1]       = in_bead_b;
    end

    evf_bead_store #(.DEPTH(BEAD_DEPTH), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (upd_en),
        .wr_id   (upd_bead),
        .wr_time (upd_time),
        .rd_id   (look_id),
        .rd_time (look_time)
    );

    // Stage 1: hold the record alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_rec   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_rec <= in_rec;
        end
    end

    evf_stale_check u_check (
        .rec    (s1_rec),
        .last_a (look_time[0]),
        .last_b (look_time[1]),
        .keep   (keep)
    );

    assign pass_now = s1_valid && keep;
    assign drop_now = s1_valid && !keep;

    // Stage 2: register the surviving record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_rec   <= '0;
        end else begin
            s2_valid <= pass_now;
            if (pass_now) s2_rec <= s1_rec;
        end
    end

    evf_tally #(.W(CNT_W)) u_pass (
        .clk (clk), .rst_n (rst_n), .bump (pass_now), .count (pass_count)
    );
    evf_tally #(.W(CNT_W)) u_drop (
        .clk (clk), .rst_n (rst_n), .bump (drop_now), .count (drop_count)
    );

    // Drive the output ports from stage 2.
    always_comb begin
        out_valid     = s2_valid;
        out_evt_time  = s2_rec.evt_time;
        out_pred_time = s2_rec.pred_time;
        out_bead_a    = s2_rec.bead_a;
        out_bead_b    = s2_rec.bead_b;
        out_b_used    = s2_rec.b_used;
    end
endmodule

// File: rtl/evf_drain_filter_chk.sv
// Property checker for the drain filter; attached by the bind below.
module evf_drain_filter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [31:0]      out_pred_time,
    input logic             out_b_used,
    input logic [31:0]      last_a,
    input logic [31:0]      last_b,
    input logic [CNT_W-1:0] pass_count,
    input logic [CNT_W-1:0] drop_count
);
    logic [CNT_W-1:0] total;
    assign total = pass_count + drop_count;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !out_valid && pass_count == '0 && drop_count == '0); // R1
    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid, 2)); // R2
    AST_KEPT_A_FRESH: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(last_a) <= out_pred_time); // R4
    AST_KEPT_B_FRESH: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_b_used) |-> $past(last_b) <= out_pred_time); // R6
    AST_EVERY_INPUT_DECIDED: assert property (@(posedge clk) disable iff (!rst_n) $past(in_valid, 2) |-> total == $past(total) + 1'b1); // R9
    AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> pass_count == $past(pass_count) + 1'b1); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(in_valid, 2) |-> $stable(pass_count) && $stable(drop_count)); // R10
endmodule

bind evf_drain_filter evf_drain_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .out_valid     (out_valid),
    .out_pred_time (out_pred_time),
    .out_b_used    (out_b_used),
    .last_a        (look_time[0]),
    .last_b        (look_time[1]),
    .pass_count    (pass_count),
    .drop_count    (drop_count)
);

// File: tb/sim_evf_drain_filter.sv
// Directed bench: one task per scenario; inputs change 1 ns after a rising edge
// and outputs are sampled at the same point.
module sim_evf_drain_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_evt_time = '0;
    logic [31:0] in_pred_time = '0;
    logic [15:0] in_bead_a = '0;
    logic [15:0] in_bead_b = '0;
    logic        in_b_used = 1'b0;
    logic        upd_en = 1'b0;
    logic [15:0] upd_bead = '0;
    logic [31:0] upd_time = '0;
    logic        out_valid;
    logic [31:0] out_evt_time;
    logic [31:0] out_pred_time;
    logic [15:0] out_bead_a;
    logic [15:0] out_bead_b;
    logic        out_b_used;
    logic [15:0] pass_count;
    logic [15:0] drop_count;

    int n_checks = 0;
    int n_fail = 0;
    int exp_pass = 0;
    int exp_drop = 0;

    always #5 clk = ~clk;

    evf_drain_filter u0 (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [31:0] et, input logic [31:0] pt,
                       input logic [15:0] a, input logic [15:0] b, input logic bu);
        in_valid = 1'b1; in_evt_time = et; in_pred_time = pt;
        in_bead_a = a; in_bead_b = b; in_b_used = bu;
    endtask

    task automatic set_bead(input logic [15:0] b, input logic [31:0] t);
        upd_en = 1'b1; upd_bead = b; upd_time = t;
        step();
        upd_en = 1'b0;
    endtask

    // Present one record, then check cycle c+2 for pass or drop.
    task automatic one(input string req, input logic [31:0] et, input logic [31:0] pt,
                       input logic [15:0] a, input logic [15:0] b, input logic bu,
                       input logic exp_keep);
        put(et, pt, a, b, bu);
        step();
        in_valid = 1'b0;
        step();
        check(req, {63'd0, out_valid}, {63'd0, exp_keep});
        if (exp_keep) begin
            exp_pass++;
            check(req, {out_evt_time, out_pred_time}, {et, pt});
            check(req, {31'd0, out_bead_a, out_bead_b, out_b_used}, {31'd0, a, b, bu});
        end else exp_drop++;
        check(req, {32'd0, pass_count, drop_count}, {32'd0, exp_pass[15:0], exp_drop[15:0]});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check("R1 during reset", {46'd0, out_valid, pass_count, drop_count}, 64'd0);
        rst_n = 1'b1;
        step();
        check("R1 after reset", {46'd0, out_valid, pass_count, drop_count}, 64'd0);
    endtask

    task automatic t_fresh();
        one("R3 unwritten beads", 32'd40, 32'd1, 16'd5, 16'd6, 1'b1, 1'b1);
        one("R2 fields carried", 32'hDEAD_0001, 32'h0000_0010, 16'd7, 16'd0, 1'b0, 1'b1);
    endtask

    task automatic t_bead_a();
        set_bead(16'd3, 32'd100);
        one("R4 bead A newer", 32'd90, 32'd50, 16'd3, 16'd8, 1'b1, 1'b0);
        one("R5 equal times kept", 32'd120, 32'd100, 16'd3, 16'd8, 1'b1, 1'b1);
    endtask

    task automatic t_bead_b();
        set_bead(16'd9, 32'd200);
        one("R6 bead B newer", 32'd300, 32'd150, 16'd1, 16'd9, 1'b1, 1'b0);
        one("R7 bead B unused", 32'd300, 32'd150, 16'd1, 16'd9, 1'b0, 1'b1);
    endtask

    task automatic t_forward();
        set_bead(16'd20, 32'd5);
        upd_en = 1'b1; upd_bead = 16'd20; upd_time = 32'd30;
        one("R8 same-cycle update makes stale", 32'd60, 32'd10, 16'd20, 16'd0, 1'b0, 1'b0);
        upd_en = 1'b0;
        set_bead(16'd22, 32'd50);
        upd_en = 1'b1; upd_bead = 16'd22; upd_time = 32'd4;
        one("R8 same-cycle update makes fresh", 32'd60, 32'd10, 16'd0, 16'd22, 1'b1, 1'b1);
        upd_en = 1'b0;
        one("R8 update persists", 32'd60, 32'd10, 16'd20, 16'd0, 1'b0, 1'b0);
    endtask

    task automatic t_stream();
        logic [15:0] ba [6];
        logic [31:0] pt [6];
        logic        kp [6];
        ba = '{16'd3, 16'd7, 16'd9, 16'd3, 16'd11, 16'd20};
        pt = '{32'd99, 32'd0, 32'd250, 32'd101, 32'd0, 32'd29};
        kp = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
        for (int j = 0; j < 8; j++) begin
            if (j >= 2) begin
                check("R9 stream output", {63'd0, out_valid}, {63'd0, kp[j-2]});
                if (kp[j-2]) begin
                    exp_pass++;
                    check("R9 stream bead", {48'd0, out_bead_a}, {48'd0, ba[j-2]});
                end else exp_drop++;
                check("R10 stream counts", {32'd0, pass_count, drop_count},
                      {32'd0, exp_pass[15:0], exp_drop[15:0]});
            end
            if (j < 6) put(32'd1000 + j, pt[j], ba[j], 16'd0, 1'b0);
            else in_valid = 1'b0;
            step();
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fresh();
        t_bead_a();
        t_bead_b();
        t_forward();
        t_stream();
        check("R10 final pass", {48'd0, pass_count}, {48'd0, exp_pass[15:0]});
        check("R10 final drop", {48'd0, drop_count}, {48'd0, exp_drop[15:0]});
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule